// File: doc/BRIEF.md
# Processor Init Pulse Generator

This block drives the processor initialization line. Four separate events can start a pulse: a write to the reset-control register that raises its CPU-reset bit, a decoded shutdown cycle on the bus, a falling edge on an external active-low reset request from the keyboard controller, and a write that sets bit 0 of the fast-reset port. Whichever event comes first, the block drives one pulse of fixed length, counted in bus clocks.

A static strap selects the pulse polarity, so the same block can serve a processor that wants an active-high line or one that wants an active-low line. While a pulse is running, further events are dropped. Bus decode, pad drivers and the wider reset sequence belong to other blocks.

Top module: `init_pulse_gen`

## Requirements
- R1: A reset-control write with bit 2 (CPU reset) = 1 and bit 1 (full system reset) = 0 starts a pulse when the stored copy of bit 2 is 0. The output is asserted from the clock edge that samples the write.
- R2: A reset-control write with bit 1 = 1 starts no pulse, even when bit 2 rises.
- R3: The stored copy of bit 2 is updated on every reset-control write. A write with bit 2 = 1 while the copy is already 1 starts no pulse.
- R4: A one-cycle shutdown strobe starts a pulse from the edge that samples it.
- R5: A fast-port write with bit 0 = 1 starts a pulse from the edge that samples it. A fast-port write with bit 0 = 0 has no effect.
- R6: The external reset request is synchronized by two flops and acts only on its falling edge. The pulse is asserted after the third clock edge following the fall. Holding the request low gives exactly one pulse.
- R7: Every pulse lasts exactly PULSE_CYCLES (default 64) clocks. The output then returns to its inactive level.
- R8: A trigger that arrives while a pulse is running neither extends nor restarts that pulse.
- R9: When strap_active_high_i = 1, the asserted level is 1 and the idle level is 0. When the strap is 0, both levels are inverted.
- R10: During reset and after its release, the output sits at its inactive level until a trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_active_high_i | input | 1 | Polarity strap, 1 = active-high output |
| rstctl_we_i | input | 1 | Reset-control register write strobe |
| rstctl_data_i | input | 8 | Reset-control write data |
| shutdown_i | input | 1 | Decoded shutdown-cycle strobe |
| ext_rst_req_ni | input | 1 | External reset request, active low, asynchronous |
| fast_we_i | input | 1 | Fast-reset port write strobe |
| fast_data_i | input | 8 | Fast-reset port write data |
| init_o | output | 1 | Processor initialization pulse |

## Verification
The register-write, shutdown and fast-port triggers act one edge after they are sampled, so the bench drives each strobe for one cycle from a falling edge and expects the output to be asserted at the next falling edge. The external request passes through three registers, so the bench expects two idle samples and then the asserted level on the third. The bench samples every falling edge of the pulse and requires exactly PULSE_CYCLES asserted samples followed by an idle one. This count also shows whether a mid-pulse trigger stretched or restarted the pulse.

// File: rtl/init_pulse_pkg.sv
package init_pulse_pkg;
  localparam int unsigned REG_W        = 8;
  localparam int unsigned CPU_RST_BIT  = 2;
  localparam int unsigned FULL_RST_BIT = 1;
  localparam int unsigned FAST_BIT     = 0;

  typedef struct packed {
    logic rstctl;
    logic shutdown;
    logic ext_req;
    logic fast;
  } trig_t;
endpackage

// File: rtl/init_rstctl_edge.sv
module init_rstctl_edge
  import init_pulse_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] data_i,
  output logic             cpu_bit_q_o,
  output logic             trig_o
);
  logic cpu_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cpu_bit_q <= 1'b0;
    else if (we_i) cpu_bit_q <= data_i[CPU_RST_BIT];
  end

  assign trig_o = we_i && data_i[CPU_RST_BIT] && !data_i[FULL_RST_BIT] && !cpu_bit_q;
  assign cpu_bit_q_o = cpu_bit_q;
endmodule

// File: rtl/init_ext_sync.sv
module init_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic fall_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= req_ni;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  // last stage holds the previous synchronized value
  assign fall_o = !sync_q[STAGES-1] && sync_q[STAGES];
endmodule

// File: rtl/init_pulse_timer.sv
module init_pulse_timer #(
  parameter int unsigned PULSE_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int unsigned CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYCLES - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_LAST;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/init_pulse_gen.sv
module init_pulse_gen
  import init_pulse_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 64,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_active_high_i,
  input  logic             rstctl_we_i,
  input  logic [REG_W-1:0] rstctl_data_i,
  input  logic             shutdown_i,
  input  logic             ext_rst_req_ni,
  input  logic             fast_we_i,
  input  logic [REG_W-1:0] fast_data_i,
  output logic             init_o
);
  trig_t trig;
  logic  cpu_bit_q;
  logic  start;
  logic  active;

  init_rstctl_edge u_rstctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (rstctl_we_i),
    .data_i      (rstctl_data_i),
    .cpu_bit_q_o (cpu_bit_q),
    .trig_o      (trig.rstctl)
  );

  init_ext_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (ext_rst_req_ni),
    .fall_o (trig.ext_req)
  );

  assign trig.shutdown = shutdown_i;
  assign trig.fast     = fast_we_i && fast_data_i[FAST_BIT];
  assign start         = |trig;

  init_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .active_o (active)
  );

  assign init_o = strap_active_high_i ? active : !active;
endmodule

// File: rtl/init_pulse_gen_chk.sv
module init_pulse_gen_chk
  import init_pulse_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strap_active_high_i,
  input logic             rstctl_we_i,
  input logic [REG_W-1:0] rstctl_data_i,
  input logic             shutdown_i,
  input logic             fast_we_i,
  input logic [REG_W-1:0] fast_data_i,
  input logic             ext_fall,
  input logic             cpu_bit_q,
  input logic             init_o
);
  localparam int unsigned RUN_W = $clog2(PULSE_CYCLES + 1) + 1;

  logic             asserted;
  logic [RUN_W-1:0] run_q;

  assign asserted = strap_active_high_i ? init_o : !init_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (asserted) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  p_reset_idle_r10: assert property (@(posedge clk_i) !rst_ni |-> !asserted);

  p_rstctl_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asserted && rstctl_we_i && rstctl_data_i[CPU_RST_BIT] &&
     !rstctl_data_i[FULL_RST_BIT] && !cpu_bit_q) |=> asserted);

  p_shutdown_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asserted && shutdown_i) |=> asserted);

  p_fast_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asserted && fast_we_i && fast_data_i[FAST_BIT]) |=> asserted);

  p_ext_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asserted && ext_fall) |=> asserted);

  p_len_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asserted |-> (run_q < RUN_W'(PULSE_CYCLES)));

  p_len_exact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asserted) |-> (run_q == RUN_W'(PULSE_CYCLES)));

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asserted) |-> $past(shutdown_i || ext_fall ||
      (fast_we_i && fast_data_i[FAST_BIT]) ||
      (rstctl_we_i && rstctl_data_i[CPU_RST_BIT] && !rstctl_data_i[FULL_RST_BIT])));
endmodule

bind init_pulse_gen init_pulse_gen_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .strap_active_high_i (strap_active_high_i),
  .rstctl_we_i         (rstctl_we_i),
  .rstctl_data_i       (rstctl_data_i),
  .shutdown_i          (shutdown_i),
  .fast_we_i           (fast_we_i),
  .fast_data_i         (fast_data_i),
  .ext_fall            (trig.ext_req),
  .cpu_bit_q           (cpu_bit_q),
  .init_o              (init_o)
);

// File: tb/sim_init_pulse_gen.sv
`timescale 1ns/1ps
module sim_init_pulse_gen;
  localparam int unsigned PULSE = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b1;
  logic       rc_we = 1'b0;
  logic [7:0] rc_data = 8'h00;
  logic       sd = 1'b0;
  logic       ext_n = 1'b1;
  logic       f_we = 1'b0;
  logic [7:0] f_data = 8'h00;
  logic       init;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  init_pulse_gen #(.PULSE_CYCLES(PULSE)) u0 (
    .clk_i               (clk),
    .rst_ni              (rst_n),
    .strap_active_high_i (strap),
    .rstctl_we_i         (rc_we),
    .rstctl_data_i       (rc_data),
    .shutdown_i          (sd),
    .ext_rst_req_ni      (ext_n),
    .fast_we_i           (f_we),
    .fast_data_i         (f_data),
    .init_o              (init)
  );

  function automatic logic lvl(input logic on);
    return strap ? on : !on;
  endfunction

  task automatic chk(input string req, input logic on);
    checks++;
    if (init !== lvl(on)) begin
      errors++;
      $display("FAIL %s: init_o=%b expected %b at %0t", req, init, lvl(on), $time);
    end
  endtask

  // strobe was sampled at the last edge; expect exactly PULSE asserted samples
  task automatic expect_pulse(input string req);
    int n = 0;
    for (int i = 0; i < PULSE + 4; i++) begin
      if (init === lvl(1'b1)) n++;
      else break;
      @(negedge clk);
    end
    checks++;
    if (n != PULSE) begin
      errors++;
      $display("FAIL %s: pulse length %0d expected %0d", req, n, PULSE);
    end
    chk(req, 1'b0);
  endtask

  task automatic expect_idle(input string req, input int cyc);
    for (int i = 0; i < cyc; i++) begin
      chk(req, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0;
    strap = s;
    repeat (3) @(negedge clk);
    chk("R10", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", 1'b0);
    repeat (3) @(negedge clk);
    chk("R10", 1'b0);
  endtask

  task automatic rc_write(input logic [7:0] d);
    rc_we = 1'b1; rc_data = d;
    @(negedge clk);
    rc_we = 1'b0; rc_data = 8'h00;
  endtask

  task automatic t_rstctl;
    rc_write(8'h04);
    expect_pulse("R1");
    expect_idle("R3", 2);
    rc_write(8'h04);
    expect_idle("R3", 4);
    rc_write(8'h00);
    expect_idle("R3", 2);
    rc_write(8'h06);
    expect_idle("R2", 4);
    rc_write(8'h04);
    expect_idle("R3", 4);
    rc_write(8'h00);
    rc_write(8'h04);
    expect_pulse("R1");
    rc_write(8'h00);
  endtask

  task automatic t_shutdown;
    sd = 1'b1;
    @(negedge clk);
    sd = 1'b0;
    expect_pulse("R4");
    expect_idle("R4", 2);
  endtask

  task automatic t_fast;
    f_we = 1'b1; f_data = 8'hFE;
    @(negedge clk);
    f_we = 1'b0; f_data = 8'h00;
    expect_idle("R5", 4);
    f_we = 1'b1; f_data = 8'h01;
    @(negedge clk);
    f_we = 1'b0; f_data = 8'h00;
    expect_pulse("R5");
    expect_idle("R5", 2);
  endtask

  task automatic t_ext;
    ext_n = 1'b0;
    @(negedge clk); chk("R6", 1'b0);
    @(negedge clk); chk("R6", 1'b0);
    @(negedge clk);
    expect_pulse("R6");
    expect_idle("R6", 40);
    ext_n = 1'b1;
    expect_idle("R6", 5);
  endtask

  task automatic t_busy;
    int n = 1;
    sd = 1'b1;
    @(negedge clk);
    sd = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (init === lvl(1'b1)) n++;
      @(negedge clk);
    end
    f_we = 1'b1; f_data = 8'h01;
    @(negedge clk);
    f_we = 1'b0; f_data = 8'h00;
    rc_write(8'h04);
    sd = 1'b1;
    @(negedge clk);
    sd = 1'b0;
    n += 3;
    while (init === lvl(1'b1) && n < PULSE + 20) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != PULSE + 1) begin
      errors++;
      $display("FAIL R8: samples through pulse %0d expected %0d", n, PULSE + 1);
    end
    expect_idle("R8", 4);
    rc_write(8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset(1'b1);
    t_rstctl();
    t_shutdown();
    t_fast();
    t_ext();
    t_busy();
    do_reset(1'b0);
    chk("R9", 1'b0);
    t_shutdown();
    t_fast();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule